// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block deserialises one stereo audio stream. It runs in the bit-clock domain: its clock is the serial bit clock. On every rising edge it samples the word clock and the serial data line. A 3-bit format input selects one of five framings:

- 16-bit, 20-bit or 24-bit right-justified, with the sample ending at the half-frame boundary;
- 24-bit left-justified;
- I2S-style, with the MSB delayed by one bit clock and the word-clock polarity inverted.

The receiver finds the half-frame boundaries from the word clock itself. It holds the left sample until the right half-frame closes. It then presents both samples, sign-extended to the output width, together with a single-cycle strobe.

For the right-justified formats, the receiver does not need to know how many bit clocks a half-frame holds. A shift register keeps the newest bits, and the last N of them are taken when the word clock toggles. For the left-justified and I2S formats, a position counter places each bit into the sample directly.

Top module: `audio_fmt_rx`

## Requirements
- R1: While reset is asserted and after its release, `smp_valid` is 0 and both sample outputs are 0 until the first completed frame.
- R2: With `fmt_sel` = 000, each sample is the last 16 bits before the word-clock toggle, sign-extended to 24 bits; earlier bits in the half-frame have no effect.
- R3: With `fmt_sel` = 001, each sample is the last 20 bits before the toggle, sign-extended to 24 bits; earlier bits have no effect.
- R4: With `fmt_sel` = 100, each sample is the last 24 bits before the toggle; earlier bits have no effect.
- R5: The right-justified formats give the same samples whether a half-frame holds exactly the sample width in bit clocks or 32 bit clocks.
- R6: With `fmt_sel` = 010, the MSB is the bit sampled on the first rising edge after the toggle, and 24 bits follow MSB-first. Bits after the 24th have no effect, and 16-bit or 20-bit data padded with zero low bits is returned unchanged.
- R7: With `fmt_sel` = 011, the MSB is the bit sampled on the second rising edge after the toggle, and word clock low marks the left channel. With 24 bit clocks per half-frame, the LSB is the first bit of the following half-frame.
- R8: In every format except 011, the half-frame with word clock high is the left channel. Left and right samples are never swapped.
- R9: `smp_valid` is high for exactly one cycle per frame. It rises on the first rising edge that samples the word clock at its left-channel level after a right half-frame, and that same edge updates both samples.
- R10: A half-frame not opened by a word-clock toggle after reset is discarded, and no strobe is issued for a right half-frame without a preceding complete left half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Framing select: 000 16-bit right-justified, 001 20-bit right-justified, 010 24-bit left-justified, 011 I2S, 100 24-bit right-justified |
| wclk | input | 1 | Left/right word clock |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| left_smp | output | 24 | Left sample, sign-extended |
| right_smp | output | 24 | Right sample, sign-extended |
| smp_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
A sample pair is due on the clock edge that samples the first bit of the next left half-frame. The outputs and the strobe are registered, so the pair is visible in the half cycle that follows that edge.

While it drives a frame, the bench pushes the expected pair together with the cycle number of that edge. The monitor samples on falling edges. It requires each strobe to land on exactly the recorded cycle with the recorded values, and it flags any strobe that arrives when nothing is expected.

Bits outside each sample window are filled with random values, so any dependence on them shows up as a value mismatch.

// File: rtl/afr_pkg.sv
package afr_pkg;
   localparam logic [2:0] FMT_L16 = 3'b000;
   localparam logic [2:0] FMT_L20 = 3'b001;
   localparam logic [2:0] FMT_MSB = 3'b010;
   localparam logic [2:0] FMT_I2S = 3'b011;
   localparam logic [2:0] FMT_L24 = 3'b100;

   localparam int LSB_VARIANTS = 3;

   function automatic int lsb_width(input int idx);
      case (idx)
         0:       return 16;
         1:       return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [2:0] lsb_code(input int idx);
      case (idx)
         0:       return FMT_L16;
         1:       return FMT_L20;
         default: return FMT_L24;
      endcase
   endfunction
endpackage

// File: rtl/afr_frame_track.sv
module afr_frame_track #(
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wclk,
   output logic             is_edge,
   output logic [POS_W-1:0] bit_idx,
   output logic [POS_W-1:0] prev_idx,
   output logic             wclk_prev,
   output logic             framed
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic             armed_q;
   logic             wclk_q;
   logic             seen_q;
   logic [POS_W-1:0] pos_q;

   always_comb begin
      is_edge = armed_q && (wclk != wclk_q);
      if (is_edge)
         bit_idx = '0;
      else if (pos_q == POS_MAX)
         bit_idx = pos_q;
      else
         bit_idx = pos_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         wclk_q  <= 1'b0;
         seen_q  <= 1'b0;
         pos_q   <= '0;
      end else begin
         armed_q <= 1'b1;
         wclk_q  <= wclk;
         pos_q   <= bit_idx;
         if (is_edge)
            seen_q <= 1'b1;
      end
   end

   assign prev_idx  = pos_q;
   assign wclk_prev = wclk_q;
   assign framed    = seen_q;

   assert_first_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wclk != wclk_q) |=> (pos_q == '0));
endmodule

// File: rtl/afr_capture.sv
module afr_capture
   import afr_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int POS_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt,
   input  logic                sdata,
   input  logic                is_edge,
   input  logic [POS_W-1:0]    bit_idx,
   input  logic [POS_W-1:0]    prev_idx,
   output logic [SAMPLE_W-1:0] done_val
);
   logic [SAMPLE_W-1:0] shreg_q;
   logic [SAMPLE_W-1:0] acc_q;
   logic [SAMPLE_W-1:0] acc_n;
   logic [SAMPLE_W-1:0] i2s_tail;
   logic [SAMPLE_W-1:0] lsb_cand [LSB_VARIANTS];
   logic                i2s_mode;
   logic                in_win;
   logic [POS_W-1:0]    slot;

   function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] v, input int w);
      logic [SAMPLE_W-1:0] r;
      for (int i = 0; i < SAMPLE_W; i++)
         r[i] = (i < w) ? v[i] : v[w-1];
      return r;
   endfunction

   genvar g;
   generate
      for (g = 0; g < LSB_VARIANTS; g++) begin : g_lsb
         assign lsb_cand[g] = sext(shreg_q, lsb_width(g));
      end
   endgenerate

   assign i2s_mode = (fmt == FMT_I2S);

   always_comb begin
      if (i2s_mode) begin
         slot   = bit_idx - 1'b1;
         in_win = (bit_idx != '0) && (int'(slot) < SAMPLE_W);
      end else begin
         slot   = bit_idx;
         in_win = (int'(bit_idx) < SAMPLE_W);
      end
      acc_n = is_edge ? '0 : acc_q;
      for (int i = 0; i < SAMPLE_W; i++)
         if (in_win && slot == POS_W'(SAMPLE_W - 1 - i))
            acc_n[i] = sdata;
   end

   always_comb begin
      i2s_tail = acc_q;
      for (int i = 0; i < SAMPLE_W; i++)
         if (prev_idx == POS_W'(SAMPLE_W - 1 - i))
            i2s_tail[i] = sdata;
   end

   always_comb begin
      case (fmt)
         FMT_L16: done_val = lsb_cand[0];
         FMT_L20: done_val = lsb_cand[1];
         FMT_L24: done_val = lsb_cand[2];
         FMT_I2S: done_val = i2s_tail;
         default: done_val = acc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         acc_q   <= '0;
      end else begin
         shreg_q <= {shreg_q[SAMPLE_W-2:0], sdata};
         acc_q   <= acc_n;
      end
   end

   assert_i2s_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge && fmt == FMT_I2S) |=> (acc_q == '0));
endmodule

// File: rtl/afr_pair.sv
module afr_pair
   import afr_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt,
   input  logic                wclk_prev,
   input  logic                is_edge,
   input  logic                framed,
   input  logic [SAMPLE_W-1:0] done_val,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   logic [SAMPLE_W-1:0] hold_q;
   logic                have_q;
   logic                done_left;

   assign done_left = (fmt == FMT_I2S) ? !wclk_prev : wclk_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         have_q  <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (is_edge && framed) begin
            if (done_left) begin
               hold_q <= done_val;
               have_q <= 1'b1;
            end else if (have_q) begin
               left_o  <= hold_q;
               right_o <= done_val;
               valid_o <= 1'b1;
               have_q  <= 1'b0;
            end
         end
      end
   end

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   assert_valid_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(is_edge));
   assert_left_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(have_q));
   assert_sext16_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(fmt) == FMT_L16) |->
      ((left_o[SAMPLE_W-1:15] == '0 || left_o[SAMPLE_W-1:15] == '1) &&
       (right_o[SAMPLE_W-1:15] == '0 || right_o[SAMPLE_W-1:15] == '1)));
   assert_sext20_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(fmt) == FMT_L20) |->
      ((left_o[SAMPLE_W-1:19] == '0 || left_o[SAMPLE_W-1:19] == '1) &&
       (right_o[SAMPLE_W-1:19] == '0 || right_o[SAMPLE_W-1:19] == '1)));
endmodule

// File: rtl/audio_fmt_rx.sv
module audio_fmt_rx #(
   parameter int SAMPLE_W = 24,
   parameter int POS_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt_sel,
   input  logic                wclk,
   input  logic                sdata,
   output logic [SAMPLE_W-1:0] left_smp,
   output logic [SAMPLE_W-1:0] right_smp,
   output logic                smp_valid
);
   localparam int POS_SPAN = 1 << POS_W;

   generate
      if (SAMPLE_W < 24) begin : g_bad_width
         $error("SAMPLE_W must hold a 24-bit sample");
      end
      if (POS_SPAN <= SAMPLE_W + 1) begin : g_bad_pos
         $error("POS_W too narrow to index a full sample plus delay slot");
      end
   endgenerate

   logic                is_edge;
   logic                wclk_prev;
   logic                framed;
   logic [POS_W-1:0]    bit_idx;
   logic [POS_W-1:0]    prev_idx;
   logic [SAMPLE_W-1:0] done_val;

   afr_frame_track #(.POS_W(POS_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .wclk      (wclk),
      .is_edge   (is_edge),
      .bit_idx   (bit_idx),
      .prev_idx  (prev_idx),
      .wclk_prev (wclk_prev),
      .framed    (framed)
   );

   afr_capture #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt_sel),
      .sdata    (sdata),
      .is_edge  (is_edge),
      .bit_idx  (bit_idx),
      .prev_idx (prev_idx),
      .done_val (done_val)
   );

   afr_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt       (fmt_sel),
      .wclk_prev (wclk_prev),
      .is_edge   (is_edge),
      .framed    (framed),
      .done_val  (done_val),
      .left_o    (left_smp),
      .right_o   (right_smp),
      .valid_o   (smp_valid)
   );
endmodule

// File: tb/audio_fmt_rx_test.sv
module audio_fmt_rx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fmt_sel = 3'b010;
   logic        wclk = 1'b0;
   logic        sdata = 1'b0;
   logic [23:0] left_smp;
   logic [23:0] right_smp;
   logic        smp_valid;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int pushed = 0;
   int seen_valid = 0;

   typedef struct {
      logic [23:0] l;
      logic [23:0] r;
      int          due;
      string       tag;
   } exp_t;

   exp_t        q[$];
   exp_t        pend;
   bit          pend_v = 0;
   logic        carry = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   audio_fmt_rx uut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wclk(wclk), .sdata(sdata),
      .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid)
   );

   task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] model(input logic [2:0] f, input logic [23:0] s);
      case (f)
         3'b000:  return {{8{s[15]}}, s[15:0]};
         3'b001:  return {{4{s[19]}}, s[19:0]};
         default: return s;
      endcase
   endfunction

   function automatic int lsb_n(input logic [2:0] f);
      case (f)
         3'b000:  return 16;
         3'b001:  return 20;
         default: return 24;
      endcase
   endfunction

   task automatic drive_half(input logic lvl, input logic [23:0] s, input int n, input bit opens_frame);
      for (int k = 0; k < n; k++) begin
         logic b;
         b = logic'($urandom() & 1);
         if (fmt_sel == 3'b011) begin
            if (k == 0) b = carry;
            else if (k <= 24) b = s[24-k];
         end else if (fmt_sel == 3'b010) begin
            if (k < 24) b = s[23-k];
         end else if (k >= n - lsb_n(fmt_sel)) begin
            b = s[n-1-k];
         end
         @(negedge clk);
         wclk  = lvl;
         sdata = b;
         if (k == 0 && opens_frame && pend_v) begin
            pend.due = cyc + 1;
            q.push_back(pend);
            pushed++;
            pend_v = 0;
         end
      end
      carry = (n == 24) ? s[0] : logic'($urandom() & 1);
   endtask

   task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int n, input string tag);
      logic lft;
      lft = (fmt_sel == 3'b011) ? 1'b0 : 1'b1;
      drive_half(lft, l, n, 1);
      drive_half(!lft, r, n, 0);
      pend.l = model(fmt_sel, l);
      pend.r = model(fmt_sel, r);
      pend.tag = tag;
      pend_v = 1;
   endtask

   task automatic flush();
      logic lft;
      lft = (fmt_sel == 3'b011) ? 1'b0 : 1'b1;
      drive_half(lft, 24'h0, 8, 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic start_group(input logic [2:0] f, input bit idle_left);
      logic lft;
      @(negedge clk);
      rst_n = 1'b0;
      fmt_sel = f;
      lft = (f == 3'b011) ? 1'b0 : 1'b1;
      wclk = idle_left ? lft : !lft;
      sdata = 1'b0;
      pend_v = 0;
      carry = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && smp_valid) begin
         seen_valid++;
         if (q.size() == 0) begin
            check(1'b0, "R9 unexpected strobe", left_smp, 24'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(left_smp == e.l, {e.tag, " left"}, left_smp, e.l);
            check(right_smp == e.r, {e.tag, " right"}, right_smp, e.r);
            check(cyc == e.due, "R9 strobe cycle", 24'(cyc), 24'(e.due));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check(smp_valid == 1'b0, "R1 valid in reset", 24'(smp_valid), 24'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(smp_valid == 1'b0, "R1 valid after reset", 24'(smp_valid), 24'h0);
      check(left_smp == 24'h0, "R1 left after reset", left_smp, 24'h0);
      check(right_smp == 24'h0, "R1 right after reset", right_smp, 24'h0);

      // R6 R8 left-justified, 24 and 32 clocks per half-frame
      start_group(3'b010, 0);
      send_frame(24'h123456, 24'hABCDEF, 24, "R6 R8");
      send_frame(24'h800001, 24'h7FFFFE, 32, "R6 R8");
      send_frame(24'h123400, 24'hFFF000, 32, "R6 padded");
      flush();

      // R10 partial opening half-frame discarded
      start_group(3'b010, 1);
      drive_half(1'b1, 24'h5A5A5A, 10, 0);
      drive_half(1'b0, 24'h3C3C3C, 24, 0);
      send_frame(24'h010203, 24'hF0E0D0, 24, "R10");
      flush();

      // R7 I2S, 24 and 32 clocks
      start_group(3'b011, 0);
      send_frame(24'h89ABCD, 24'h456789, 24, "R7");
      send_frame(24'hC00003, 24'h3FFFFC, 24, "R7");
      send_frame(24'h000001, 24'hFFFFFF, 32, "R7");
      flush();

      // R2 R5 16-bit right-justified
      start_group(3'b000, 0);
      send_frame(24'h00_8001, 24'h00_7FFF, 16, "R2 R5");
      send_frame(24'h00_1234, 24'h00_F00F, 32, "R2 R5");
      flush();

      // R3 R5 20-bit right-justified
      start_group(3'b001, 0);
      send_frame(24'h0_80000, 24'h0_7ABCD, 20, "R3 R5");
      send_frame(24'h0_FFFFF, 24'h0_00010, 32, "R3 R5");
      flush();

      // R4 R5 24-bit right-justified
      start_group(3'b100, 0);
      send_frame(24'hFEDCBA, 24'h000055, 24, "R4 R5");
      send_frame(24'h7A0B1C, 24'h876543, 32, "R4 R5");
      flush();

      check(q.size() == 0, "R9 missing strobes", 24'(q.size()), 24'h0);
      check(seen_valid == pushed, "R9 strobe count", 24'(seen_valid), 24'(pushed));
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule